// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block raises a periodic interrupt request from a 12-bit down-counter. A one-cycle enable pulse at 32.768 kHz (`tick_i`) feeds a shared divider. The divider provides four countdown rates: 4096 Hz, 64 Hz, 1 Hz and once per minute. Software writes a 12-bit reload value across two byte registers, picks a rate and sets a run bit. The counter then steps down once per period of the chosen rate. When it reaches zero it signals an event, reloads and keeps going, so events repeat every reload × rate-period.

Each event sets a sticky status flag, which software clears by writing a zero to it. If interrupts are enabled, the event also drives the active-low request output low. The request releases itself after a fixed window of 32.768 kHz ticks, or at once when the interrupt enable is cleared, even while the flag stays set. The bus front end and the pad driver sit outside this block. The block exposes a plain write strobe with address and data, and a combinational read port.

Register map (2-bit address): 0 = reload bits 7..0; 1 = reload bits 11..8 in data bits 3..0 (bits 7..4 read as 0); 2 = configuration: bit 0 run, bits 2..1 rate select (00 = 4096 Hz, 01 = 64 Hz, 10 = 1 Hz, 11 = per minute), bit 3 interrupt enable, bits 7..4 read as 0; 3 = status: bit 0 event flag, other bits read as 0.

Top module: `periodic_countdown`

## Requirements
- R1: After reset every register reads 0 and `irq_n_o` is 1.
- R2: Address 0 stores reload bits 7..0 and address 1 stores reload bits 11..8 from data bits 3..0. Address 1 bits 7..4 and address 2 bits 7..4 read back as 0.
- R3: The count advances once per DIV_FAST, DIV_MED or DIV_SLOW ticks for rate codes 00, 01 and 10, and once per DIV_SLOW × SEC_PER_MIN ticks for code 11.
- R4: A 0→1 change of the run bit loads the reload value and restarts the divider. The first event comes reload × rate-period ticks after that load, and later events follow at the same spacing.
- R5: A reload value of zero produces no events.
- R6: Every event sets the status flag (address 3 bit 0), and the flag stays 1 after the interrupt request releases.
- R7: Writing address 3 with data bit 0 = 0 clears the flag. Writing data bit 0 = 1 leaves it unchanged. An event in the same cycle as a clear wins.
- R8: An event drives `irq_n_o` low only if the interrupt enable bit is 1 at the time of the event.
- R9: `irq_n_o` returns high PULSE_TICKS ticks after the event that drove it low, whatever the flag holds.
- R10: Clearing the interrupt enable bit releases a low `irq_n_o` on the next clock edge.
- R11: While the run bit is 0 the counter makes no events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse at 32.768 kHz |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Read data for `rd_addr_i` (combinational) |
| irq_n_o | output | 1 | Active-low interrupt request, self-releasing |

## Verification
The assertions check a set of cycle-level relations on every clock:
- the flag being set after each event and holding until a clear;
- the counter holding between rate strobes and reloading after an event;
- every falling edge of the request being preceded by an event;
- the request being released one edge after the enable drops;
- the release window never exceeding its length.

Only the bench scenarios can show the absolute spacing of events in ticks for every rate and several reload values, the exact width of the release window, the behaviour of a zero reload, and the restart from a full period after the run bit is toggled.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  localparam int RELOAD_W = 12;

  typedef enum logic [1:0] {
    RATE_FAST = 2'b00,
    RATE_MED  = 2'b01,
    RATE_SLOW = 2'b10,
    RATE_MIN  = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    A_RLD_LO = 2'd0,
    A_RLD_HI = 2'd1,
    A_CFG    = 2'd2,
    A_STAT   = 2'd3
  } addr_e;

  typedef struct packed {
    logic  irq_en;
    rate_e rate;
    logic  run;
  } cfg_t;

endpackage

// File: rtl/pcd_regs.sv
module pcd_regs
  import pcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [1:0]          rd_addr,
  input  logic                evt,
  output logic [7:0]          rd_data,
  output logic [RELOAD_W-1:0] reload,
  output cfg_t                cfg,
  output logic                flag
);

  logic [7:0]          rld_lo_q;
  logic [RELOAD_W-9:0] rld_hi_q;
  cfg_t                cfg_q;
  logic                flag_q;

  logic lo_en, hi_en, cfg_en, clr_wr, flag_en, flag_d;

  // next-state and enables
  always_comb begin
    lo_en   = wr_en && (addr_e'(wr_addr) == A_RLD_LO);
    hi_en   = wr_en && (addr_e'(wr_addr) == A_RLD_HI);
    cfg_en  = wr_en && (addr_e'(wr_addr) == A_CFG);
    clr_wr  = wr_en && (addr_e'(wr_addr) == A_STAT) && !wr_data[0];
    flag_en = evt || clr_wr;
    flag_d  = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_lo_q <= '0;
      rld_hi_q <= '0;
      cfg_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (lo_en)   rld_lo_q <= wr_data;
      if (hi_en)   rld_hi_q <= wr_data[RELOAD_W-9:0];
      if (cfg_en)  cfg_q    <= cfg_t'(wr_data[3:0]);
      if (flag_en) flag_q   <= flag_d;
    end
  end

  always_comb begin
    unique case (addr_e'(rd_addr))
      A_RLD_LO: rd_data = rld_lo_q;
      A_RLD_HI: rd_data = {{(16-RELOAD_W){1'b0}}, rld_hi_q};
      A_CFG:    rd_data = {4'b0000, cfg_q};
      A_STAT:   rd_data = {7'b0000000, flag_q};
      default:  rd_data = '0;
    endcase
  end

  assign reload = {rld_hi_q, rld_lo_q};
  assign cfg    = cfg_q;
  assign flag   = flag_q;

  AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);  // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && wr_addr == 2'd3 && !wr_data[0])) |=> flag_q);  // R7

endmodule

// File: rtl/pcd_prescale.sv
module pcd_prescale
  import pcd_pkg::*;
#(
  parameter int DIV_FAST    = 8,
  parameter int DIV_MED     = 512,
  parameter int DIV_SLOW    = 32768,
  parameter int SEC_PER_MIN = 60
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  restart,
  input  rate_e rate,
  output logic  strobe
);

  localparam int FW = $clog2(DIV_FAST);
  localparam int MW = $clog2(DIV_MED);
  localparam int SW = $clog2(DIV_SLOW);

  logic [SW-1:0] div_q, div_d;
  logic          div_en;
  logic          fast_hit, med_hit, slow_hit, min_hit, sel_hit;

  always_comb begin
    fast_hit = &div_q[FW-1:0];
    med_hit  = &div_q[MW-1:0];
    slow_hit = &div_q;
    div_en   = tick || restart;
    div_d    = restart ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  generate
    if (SEC_PER_MIN > 1) begin : g_minute
      localparam int NW = $clog2(SEC_PER_MIN);
      logic [NW-1:0] sec_q, sec_d;
      logic          sec_en, sec_last;

      always_comb begin
        sec_last = (sec_q == NW'(SEC_PER_MIN - 1));
        sec_en   = restart || (tick && slow_hit);
        if (restart || sec_last) sec_d = '0;
        else                     sec_d = sec_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sec_q <= '0;
        else if (sec_en) sec_q <= sec_d;
      end

      assign min_hit = slow_hit && sec_last;
    end else begin : g_no_minute
      assign min_hit = slow_hit;
    end
  endgenerate

  always_comb begin
    unique case (rate)
      RATE_FAST: sel_hit = fast_hit;
      RATE_MED:  sel_hit = med_hit;
      RATE_SLOW: sel_hit = slow_hit;
      RATE_MIN:  sel_hit = min_hit;
      default:   sel_hit = 1'b0;
    endcase
    strobe = tick && !restart && sel_hit;
  end

endmodule

// File: rtl/pcd_counter.sv
module pcd_counter
  import pcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                strobe,
  input  logic [RELOAD_W-1:0] reload,
  output logic                start,
  output logic                evt
);

  logic [RELOAD_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;
  logic                run_q;

  always_comb begin
    start  = run && !run_q;
    cnt_en = start || (run && strobe);
    evt    = run && !start && strobe && (reload != '0) && (cnt_q == RELOAD_W'(1));
    if (start || cnt_q <= RELOAD_W'(1)) cnt_d = reload;
    else                                cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !strobe) |=> $stable(cnt_q));  // R3
  AST_RELOAD_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cnt_q == $past(reload)));  // R4
  AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !evt);  // R11

endmodule

// File: rtl/pcd_irq.sv
module pcd_irq #(
  parameter int PULSE_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic evt,
  input  logic irq_en,
  output logic irq_n
);

  localparam int WW = $clog2(PULSE_TICKS + 1);

  logic [WW-1:0] win_q, win_d;
  logic          act_q, act_d;

  always_comb begin
    act_d = act_q;
    win_d = win_q;
    if (!irq_en) begin
      act_d = 1'b0;
      win_d = '0;
    end else if (evt) begin
      act_d = 1'b1;
      win_d = WW'(PULSE_TICKS);
    end else if (act_q && tick) begin
      if (win_q <= WW'(1)) begin
        act_d = 1'b0;
        win_d = '0;
      end else begin
        win_d = win_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      win_q <= '0;
    end else begin
      act_q <= act_d;
      win_q <= win_d;
    end
  end

  assign irq_n = !act_q;

  AST_RELEASE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> irq_n);  // R10
  AST_FALL_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(evt));  // R8
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WW'(PULSE_TICKS));  // R9

endmodule

// File: rtl/periodic_countdown.sv
module periodic_countdown
  import pcd_pkg::*;
#(
  parameter int DIV_FAST    = 8,
  parameter int DIV_MED     = 512,
  parameter int DIV_SLOW    = 32768,
  parameter int SEC_PER_MIN = 60,
  parameter int PULSE_TICKS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       irq_n_o
);

  logic [1:0]          rst_sync_q;
  logic                rst_s_n;
  logic [RELOAD_W-1:0] reload;
  cfg_t                cfg;
  logic                flag;
  logic                start, strobe, evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  pcd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .rd_addr (rd_addr_i),
    .evt     (evt),
    .rd_data (rd_data_o),
    .reload  (reload),
    .cfg     (cfg),
    .flag    (flag)
  );

  pcd_prescale #(
    .DIV_FAST    (DIV_FAST),
    .DIV_MED     (DIV_MED),
    .DIV_SLOW    (DIV_SLOW),
    .SEC_PER_MIN (SEC_PER_MIN)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick    (tick_i),
    .restart (start),
    .rate    (cfg.rate),
    .strobe  (strobe)
  );

  pcd_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run    (cfg.run),
    .strobe (strobe),
    .reload (reload),
    .start  (start),
    .evt    (evt)
  );

  pcd_irq #(
    .PULSE_TICKS (PULSE_TICKS)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .tick   (tick_i),
    .evt    (evt),
    .irq_en (cfg.irq_en),
    .irq_n  (irq_n_o)
  );

  AST_IRQ_IMPLIES_FLAG_SEEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(irq_n_o) |-> flag);  // R6

endmodule

// File: tb/periodic_countdown_test.sv
module periodic_countdown_test;

  localparam int DF = 2, DM = 4, DS = 8, SPM = 3, PT = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       irq_n;

  periodic_countdown #(
    .DIV_FAST(DF), .DIV_MED(DM), .DIV_SLOW(DS),
    .SEC_PER_MIN(SPM), .PULSE_TICKS(PT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_n_o(irq_n)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int ticks = 0, cyc = 0, base = 0;
  int n_falls = 0, f1 = 0, f2 = 0, r1 = -1;
  logic irq_prev = 1'b1, phase = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (tick) ticks++;
    if (irq_prev && !irq_n) begin
      n_falls++;
      if (n_falls == 1) f1 = ticks;
      else if (n_falls == 2) f2 = ticks;
    end
    if (!irq_prev && irq_n && n_falls == 1 && r1 < 0) r1 = ticks;
    irq_prev = irq_n;
    phase = ~phase;
    tick  = phase;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      summary();
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = 2'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic start(input int p, input int rate, input bit en);
    wr(0, p & 8'hFF);
    wr(1, (p >> 8) & 8'h0F);
    wr(2, {4'b0, en, 2'(rate), 1'b1});
    cycle();
    base = ticks; n_falls = 0; r1 = -1;
  endtask

  task automatic stop();
    wr(2, 0);
    wr(3, 0);
  endtask

  function automatic int rate_div(input int r);
    case (r)
      0: return DF;
      1: return DM;
      2: return DS;
      default: return DS * SPM;
    endcase
  endfunction

  initial begin
    int v;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) cycle();
    rst_n = 1'b1;
    repeat (4) cycle();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a, v); chk("R1 reg", v, 0); end
    chk("R1 irq_n", int'(irq_n), 1);

    // R2 split reload and unused bits
    wr(0, 8'hA5); wr(1, 8'hFB); wr(2, 8'hF0);
    rd(0, v); chk("R2 lo", v, 8'hA5);
    rd(1, v); chk("R2 hi nibble", v, 8'h0B);
    rd(2, v); chk("R2 cfg upper zero", v, 0);
    wr(0, 0); wr(1, 0);

    // R3 R4 R6 R9 sweep of rates and reload values
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 3; k++) begin
        int p, per, lim;
        p = (k == 0) ? ((r >= 2) ? 1 : 3) : ((k == 1) ? 4 : 7);
        per = p * rate_div(r);
        start(p, r, 1'b1);
        lim = 4 * per + 40;
        for (int i = 0; i < lim && n_falls < 2; i++) cycle();
        chk("R4 first event", f1 - base, per);
        chk("R3 period", f2 - f1, per);
        chk("R9 release width", r1 - f1, PT);
        rd(3, v); chk("R6 flag set", v, 1);
        stop();
      end
    end

    // R8 events without interrupt enable
    start(3, 0, 1'b0);
    repeat (40) cycle();
    chk("R8 no fall", n_falls, 0);
    chk("R8 irq_n high", int'(irq_n), 1);
    rd(3, v); chk("R6 flag w/o enable", v, 1);
    stop();

    // R10 disable releases; R7 flag write semantics
    start(7, 0, 1'b1);
    for (int i = 0; i < 200 && n_falls < 1; i++) cycle();
    chk("R8 fall with enable", int'(irq_n), 0);
    wr(2, 8'h01);
    cycle();
    chk("R10 released", int'(irq_n), 1);
    wr(2, 0);
    rd(3, v); chk("R9 flag kept after release", v, 1);
    wr(3, 8'h01); rd(3, v); chk("R7 write one keeps", v, 1);
    wr(3, 8'hFE); rd(3, v); chk("R7 write zero clears", v, 0);

    // R5 zero reload
    start(0, 0, 1'b1);
    repeat (100) cycle();
    chk("R5 no fall", n_falls, 0);
    rd(3, v); chk("R5 flag clear", v, 0);
    stop();

    // R11 stopped counter, then R4 restart from full period
    start(7, 0, 1'b1);
    repeat (20) cycle();
    wr(2, 8'h08);
    repeat (60) cycle();
    chk("R11 no fall", n_falls, 0);
    rd(3, v); chk("R11 flag clear", v, 0);
    start(7, 0, 1'b1);
    for (int i = 0; i < 200 && n_falls < 1; i++) cycle();
    chk("R4 restart period", f1 - base, 14);
    stop();

    summary();
  end

endmodule